// File: doc/BRIEF.md
# Exposed Push-Driven Integer Adder Pipeline

This block is an integer add/subtract unit with a small register file and a pipeline that software sees and controls directly. The pipeline never drains by itself: it moves forward by exactly one slot on each issued instruction and stays frozen otherwise. Every issue does two jobs at once. It injects a new operation, built from two source registers read at that moment, into the first slot. It also names the register that receives whatever falls out of the last slot. That retiring value was injected four issues earlier.

There is no interlock, hazard detection or forwarding. A program that reads a register before the value bound for it has retired gets the older contents. Compilers or hand-written code schedule around the depth by inserting bubble pushes, or by interleaving independent computations in consecutive issues. A debug port lets a host read any register at any time and preload register contents between issues.

Top module: `xp_exposed_adder`

## Requirements
- R1: A synchronous active-high reset sets all registers to zero and empties every pipeline slot. The four issues after reset retire only bubbles, so no register is written whatever their destination.
- R2: The pipeline advances only on a clock edge where `issue_valid` is 1. Without issue, in-flight values stay put for any number of cycles and no register changes.
- R3: The value injected by issue k is written to the destination named by issue k+4.
- R4: Opcode 2'b01 computes src_a + src_b modulo 2^32.
- R5: Opcode 2'b10 computes src_a - src_b modulo 2^32.
- R6: Opcodes 2'b00 and 2'b11 inject a bubble. A retiring bubble never writes the register file, even when the destination index is nonzero.
- R7: Destination index 0 discards the retiring value. Register 0 always reads as zero, and debug writes to index 0 have no effect.
- R8: Sources are read as they are at issue time, with no stall or bypass. When the same issue retires a value into a register and reads that register as a source, the source sees the value from before the write.
- R9: `dbg_rd_data` shows the register selected by `dbg_idx` combinationally. When `dbg_wr_en` is 1, that register takes `dbg_wr_data` at the clock edge, unless a retiring write targets the same register in that cycle, in which case the retiring write wins.
- R10: Independent computations may be interleaved in consecutive issues. An instruction's destination and its operands may belong to unrelated computations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Issue strobe; advances the pipeline |
| issue_op | input | 2 | 00 bubble, 01 add, 10 subtract, 11 bubble |
| src_a_idx | input | 3 | First source register index |
| src_b_idx | input | 3 | Second source register index (subtrahend) |
| dst_idx | input | 3 | Destination of the retiring value; 0 discards |
| dbg_idx | input | 3 | Debug register select |
| dbg_wr_en | input | 1 | Debug write strobe |
| dbg_wr_data | input | 32 | Debug write data |
| dbg_rd_data | output | 32 | Contents of the selected register |

## Verification
The pipeline is invisible at the ports until a value retires. A slot that was shifted wrongly, held during idle cycles, or cleared incorrectly therefore shows up only four issues later, as a wrong value or a missing write in a register. A bad live bit shows up the same way, as a spurious write over a register that should have kept its value. Because the bench compares all eight registers after every clock, such a fault is reported on the very edge where the bad retirement lands, and the stale-read and same-issue ordering cases show up as a register holding the fresh value instead of the old one.

// File: rtl/xp_pkg.sv
package xp_pkg;

    localparam int XP_DATA_W = 32;
    localparam int XP_REG_N  = 8;
    localparam int XP_DEPTH  = 4;
    localparam int XP_IDX_W  = $clog2(XP_REG_N);

    typedef enum logic [1:0] {
        OP_PUSH = 2'b00,
        OP_ADD  = 2'b01,
        OP_SUB  = 2'b10,
        OP_RSVD = 2'b11
    } xp_op_e;

    typedef logic [XP_DATA_W-1:0] xp_word_t;

    typedef struct packed {
        logic     live;
        xp_word_t value;
    } xp_slot_t;

    localparam xp_slot_t XP_BUBBLE = '{live: 1'b0, value: '0};

    function automatic logic xp_is_arith(input xp_op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

endpackage

// File: rtl/xp_alu.sv
module xp_alu
    import xp_pkg::*;
(
    input  xp_op_e   op,
    input  xp_word_t opnd_a,
    input  xp_word_t opnd_b,
    output xp_slot_t result
);

    always_comb begin
        result = XP_BUBBLE;
        unique case (op)
            OP_ADD: begin
                result.live  = 1'b1;
                result.value = opnd_a + opnd_b;
            end
            OP_SUB: begin
                result.live  = 1'b1;
                result.value = opnd_a - opnd_b;
            end
            default: result = XP_BUBBLE;
        endcase
    end

endmodule

// File: rtl/xp_shift_pipe.sv
module xp_shift_pipe
    import xp_pkg::*;
#(
    parameter int DEPTH = XP_DEPTH
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     advance,
    input  xp_slot_t in_slot,
    output xp_slot_t out_slot,
    output logic     head_live
);

    xp_slot_t [DEPTH-1:0] st_q;
    logic     [DEPTH-1:0] live_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q[0] <= XP_BUBBLE;
        end else if (advance) begin
            st_q[0] <= in_slot;
        end
    end

    generate
        for (genvar s = 1; s < DEPTH; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    st_q[s] <= XP_BUBBLE;
                end else if (advance) begin
                    st_q[s] <= st_q[s-1];
                end
            end
        end
        for (genvar s = 0; s < DEPTH; s++) begin : g_live
            assign live_vec[s] = st_q[s].live;
        end
    endgenerate

    assign out_slot  = st_q[DEPTH-1];
    assign head_live = st_q[0].live;

    // R2: frozen while no issue
    a_r2_hold_still: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(st_q));

    // R3: new operation lands in the first slot on issue
    a_r3_inject: assert property (@(posedge clk) disable iff (rst)
        advance |=> (st_q[0] == $past(in_slot)));

    // R3: last slot takes what the slot before it held
    a_r3_shift: assert property (@(posedge clk) disable iff (rst)
        advance |=> (out_slot == $past(st_q[DEPTH-2])));

    // R1: reset empties every slot
    a_r1_reset_empty: assert property (@(posedge clk)
        rst |=> (live_vec == '0));

endmodule

// File: rtl/xp_regfile.sv
module xp_regfile
    import xp_pkg::*;
#(
    parameter int REG_N = XP_REG_N,
    localparam int IDX_W = $clog2(REG_N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_a_idx,
    input  logic [IDX_W-1:0] rd_b_idx,
    input  logic [IDX_W-1:0] dbg_idx,
    output xp_word_t         rd_a,
    output xp_word_t         rd_b,
    output xp_word_t         dbg_rd,
    input  logic             ret_we,
    input  logic [IDX_W-1:0] ret_idx,
    input  xp_word_t         ret_data,
    input  logic             dbg_we,
    input  xp_word_t         dbg_wdata
);

    xp_word_t mem [REG_N];

    assign mem[0] = '0;

    generate
        for (genvar r = 1; r < REG_N; r++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    mem[r] <= '0;
                end else if (ret_we && (ret_idx == IDX_W'(r))) begin
                    mem[r] <= ret_data;
                end else if (dbg_we && (dbg_idx == IDX_W'(r))) begin
                    mem[r] <= dbg_wdata;
                end
            end
        end
    endgenerate

    assign rd_a   = mem[rd_a_idx];
    assign rd_b   = mem[rd_b_idx];
    assign dbg_rd = mem[dbg_idx];

endmodule

// File: rtl/xp_exposed_adder.sv
module xp_exposed_adder
    import xp_pkg::*;
#(
    parameter int REG_N = XP_REG_N,
    parameter int DEPTH = XP_DEPTH,
    localparam int IDX_W = $clog2(REG_N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue_valid,
    input  logic [1:0]       issue_op,
    input  logic [IDX_W-1:0] src_a_idx,
    input  logic [IDX_W-1:0] src_b_idx,
    input  logic [IDX_W-1:0] dst_idx,
    input  logic [IDX_W-1:0] dbg_idx,
    input  logic             dbg_wr_en,
    input  logic [31:0]      dbg_wr_data,
    output logic [31:0]      dbg_rd_data
);

    xp_op_e   op;
    xp_word_t opnd_a, opnd_b;
    xp_slot_t new_slot, old_slot;
    logic     retire_we;
    logic     head_live;

    assign op = xp_op_e'(issue_op);

    xp_regfile #(.REG_N(REG_N)) u_rf (
        .clk       (clk),
        .rst       (rst),
        .rd_a_idx  (src_a_idx),
        .rd_b_idx  (src_b_idx),
        .dbg_idx   (dbg_idx),
        .rd_a      (opnd_a),
        .rd_b      (opnd_b),
        .dbg_rd    (dbg_rd_data),
        .ret_we    (retire_we),
        .ret_idx   (dst_idx),
        .ret_data  (old_slot.value),
        .dbg_we    (dbg_wr_en),
        .dbg_wdata (dbg_wr_data)
    );

    xp_alu u_alu (
        .op     (op),
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .result (new_slot)
    );

    xp_shift_pipe #(.DEPTH(DEPTH)) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .advance   (issue_valid),
        .in_slot   (new_slot),
        .out_slot  (old_slot),
        .head_live (head_live)
    );

    assign retire_we = issue_valid && old_slot.live && (dst_idx != '0);

    // R6: bubble opcodes put an empty slot at the head
    a_r6_bubble_enters: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !xp_is_arith(op)) |=> !head_live);

    // R4/R5: arithmetic opcodes put a live slot at the head
    a_r4_arith_enters: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && xp_is_arith(op)) |=> head_live);

    // R7: register 0 reads zero through the debug port
    a_r7_zero_reg: assert property (@(posedge clk) disable iff (rst)
        (dbg_idx == '0) |-> (dbg_rd_data == '0));

endmodule

// File: tb/xp_exposed_adder_test.sv
`timescale 1ns/100ps
module xp_exposed_adder_test;

    localparam real PERIOD = 10.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_valid = 1'b0;
    logic [1:0]  issue_op = 2'b00;
    logic [2:0]  src_a_idx = '0, src_b_idx = '0, dst_idx = '0, dbg_idx = '0;
    logic        dbg_wr_en = 1'b0;
    logic [31:0] dbg_wr_data = '0;
    logic [31:0] dbg_rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural reference: register values and a queue of in-flight results
    logic [31:0] mreg [8];
    logic [32:0] mq[$];

    always #(PERIOD/2) clk = ~clk;

    xp_exposed_adder uut (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_op(issue_op),
        .src_a_idx(src_a_idx), .src_b_idx(src_b_idx), .dst_idx(dst_idx),
        .dbg_idx(dbg_idx), .dbg_wr_en(dbg_wr_en), .dbg_wr_data(dbg_wr_data),
        .dbg_rd_data(dbg_rd_data)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int r = 0; r < 8; r++) mreg[r] = '0;
        mq.delete();
        for (int s = 0; s < 4; s++) mq.push_back(33'd0);
    endfunction

    task automatic compare_all(input string tag);
        for (int r = 0; r < 8; r++) begin
            dbg_idx = 3'(r);
            #0.3;
            check(dbg_rd_data, mreg[r], $sformatf("%s R9 reg%0d", tag, r));
        end
    endtask

    task automatic read_reg(input int r, input logic [31:0] exp, input string tag);
        @(negedge clk);
        dbg_idx = 3'(r);
        #0.3;
        check(dbg_rd_data, exp, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        model_reset();
        @(posedge clk); #1;
        compare_all("R1 reset");
    endtask

    task automatic dbg_write(input int r, input logic [31:0] v);
        @(negedge clk);
        dbg_idx = 3'(r); dbg_wr_data = v; dbg_wr_en = 1'b1;
        @(posedge clk); #1;
        dbg_wr_en = 1'b0;
        if (r != 0) mreg[r] = v;
        compare_all("R7 dbg write");
    endtask

    task automatic push(input logic [1:0] op, input int sa, input int sb,
                        input int d, input string tag);
        logic [31:0] a, b;
        logic [32:0] nv, ov;
        @(negedge clk);
        issue_valid = 1'b1; issue_op = op;
        src_a_idx = 3'(sa); src_b_idx = 3'(sb); dst_idx = 3'(d);
        a = mreg[sa]; b = mreg[sb];
        if (op == 2'b01)      nv = {1'b1, a + b};
        else if (op == 2'b10) nv = {1'b1, a - b};
        else                  nv = 33'd0;
        ov = mq.pop_front();
        mq.push_back(nv);
        @(posedge clk); #1;
        issue_valid = 1'b0;
        if (ov[32] && d != 0) mreg[d] = ov[31:0];
        compare_all(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            compare_all(tag);
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset();

        // R1: first four pushes after reset retire only bubbles
        dbg_write(1, 32'd77);
        for (int i = 0; i < 4; i++) push(2'b01, 1, 1, 2, "R1 empty after reset");
        read_reg(2, 32'd0, "R1 no write from reset bubble");

        // R10: interleaved d = a + b - c and h = e + f - g
        do_reset();
        dbg_write(1, 32'd11); dbg_write(2, 32'd22); dbg_write(3, 32'd5);
        dbg_write(4, 32'd40); dbg_write(5, 32'd9);  dbg_write(6, 32'd13);
        push(2'b01, 1, 2, 0, "R10 a+b");
        push(2'b01, 4, 5, 0, "R10 e+f");
        push(2'b00, 0, 0, 0, "R10 nop");
        push(2'b00, 0, 0, 0, "R10 nop");
        push(2'b00, 0, 0, 7, "R3 t retire");
        push(2'b10, 7, 3, 2, "R10 u retire, t-c issue");
        push(2'b10, 2, 6, 0, "R10 u-g issue");
        push(2'b00, 0, 0, 0, "R10 nop");
        push(2'b00, 0, 0, 0, "R10 nop");
        push(2'b00, 0, 0, 1, "R10 d retire");
        push(2'b00, 0, 0, 4, "R10 h retire");
        read_reg(1, 32'd28, "R10 d");
        read_reg(4, 32'd36, "R10 h");
        read_reg(7, 32'd33, "R3 t");

        // R8: stale read and same-issue pre-write source
        dbg_write(5, 32'd100); dbg_write(6, 32'd7);
        push(2'b01, 5, 6, 0, "R8 r5+r6");
        push(2'b00, 0, 0, 0, "R8 nop");
        push(2'b00, 0, 0, 0, "R8 nop");
        push(2'b00, 0, 0, 0, "R8 nop");
        push(2'b01, 5, 0, 5, "R8 same-issue read");
        push(2'b00, 0, 0, 0, "R8 nop");
        push(2'b00, 0, 0, 0, "R8 nop");
        push(2'b00, 0, 0, 0, "R8 nop");
        push(2'b00, 0, 0, 6, "R8 stale retire");
        read_reg(5, 32'd107, "R8 fresh sum");
        read_reg(6, 32'd100, "R8 stale operand");

        // R5 wrap, R6 reserved opcode and bubble retire with nonzero dst
        dbg_write(1, 32'd0); dbg_write(2, 32'd1); dbg_write(4, 32'hA5A5_0001);
        push(2'b10, 1, 2, 0, "R5 0-1");
        push(2'b11, 1, 2, 0, "R6 reserved op");
        push(2'b00, 2, 2, 0, "R6 bubble");
        push(2'b01, 3, 3, 0, "R4 live");
        push(2'b00, 0, 0, 3, "R5 retire");
        push(2'b00, 0, 0, 4, "R6 bubble to r4");
        push(2'b00, 0, 0, 4, "R6 bubble to r4");
        read_reg(3, 32'hFFFF_FFFF, "R5 wrap");
        read_reg(4, 32'hA5A5_0001, "R6 bubble no write");

        // R4 overflow, R7 discard, R2 hold over idle cycles
        dbg_write(1, 32'hFFFF_FFFF); dbg_write(2, 32'd2);
        push(2'b00, 0, 0, 0, "R4 flush");
        push(2'b01, 1, 2, 7, "R4 add overflow issue");
        push(2'b01, 2, 2, 0, "R7 discard source");
        idle(25, "R2 idle");
        push(2'b00, 0, 0, 0, "R2 resume");
        push(2'b00, 0, 0, 0, "R2 resume");
        push(2'b00, 0, 0, 6, "R4 retire");
        push(2'b00, 0, 0, 0, "R7 discard retire");
        read_reg(6, 32'd1, "R4 overflow sum");
        read_reg(0, 32'd0, "R7 reg0");
        dbg_write(0, 32'h1234_5678);
        read_reg(0, 32'd0, "R7 dbg write to reg0");

        // R1: reset mid-flight drops in-flight values
        push(2'b01, 6, 6, 0, "R1 in flight");
        push(2'b01, 6, 6, 0, "R1 in flight");
        do_reset();
        for (int i = 0; i < 4; i++) push(2'b00, 0, 0, 1, "R1 drained");
        read_reg(1, 32'd0, "R1 nothing retired");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule